// File: doc/BRIEF.md
# Remote Frame Buffer Bus Interface

This block lets a host, through a simple register port, drive one or two display controller chips that sit on a shared 16-bit parallel bus. The host writes a command word, parameter words or packed pixel data. It can also fetch a data or status half-word back from a chip. Every host access that needs the bus stalls the register port until the bus cycles are over. Each chip has its own select line. Two control bits choose which chips receive the traffic.

The block also keeps a pixel counter and a busy flag for a frame transfer. Software starts the transfer with a control write. The transfer is then carried out as a series of data, data-read or status-read accesses, and each of these counts the pixel counter down. When the counter reaches zero the busy flag drops, and a one-cycle frame-done pulse goes out to the display controller's interrupt status.

Register word indices: 0 system status, 1 control, 2 pixel count, 3 skip lines, 4 command, 5 parameter, 6 data, 7 data read, 8 status read, 9 config A, 10 config B.

Top module: `rfb_bus_if`

## Requirements
- R1: After reset, control (index 1) reads 2, both config registers (index 9 and 10) read 0x00310000, pixel count (index 2) reads 0, system status (index 0) reads 1, and bus_cs, bus_wr and bus_rd are low.
- R2: Control bit 2 enables chip 0 (bus_cs[0]) and control bit 3 enables chip 1 (bus_cs[1]). Writes go to every enabled chip, all chip-0 beats come before any chip-1 beat, and the two selects are never high together.
- R3: A write to the command register (index 4) gives one write beat per enabled chip, with bus_dc low and bus_dout equal to bits 15:0 of the written value.
- R4: A write to the parameter register (index 5) gives one write beat per enabled chip, with bus_dc high and bus_dout equal to bits 15:0.
- R5: A write to the data register (index 6) gives two write beats per enabled chip, with bus_dc high: first bits 15:0, then bits 31:16.
- R6: In each beat, the select and exactly one strobe (bus_wr or bus_rd) are high for STROBE_CLKS clocks, followed by one clock with all of them low. For a bus access with N beats, host_ready stays low for 1 + N*(STROBE_CLKS+1) clocks from the first request clock, then goes high for one clock. With no chip enabled, N is 0.
- R7: A write to the data-read register (index 7, bus_dc high) or the status-read register (index 8, bus_dc low) gives one read beat to the lowest enabled chip only, with bus_dout at 0. bus_din is captured in the last strobe clock. Reading index 7 or 8 returns the captured half-word in bits 15:0.
- R8: Each data, data-read or status-read access lowers the pixel count by one, and the count holds at zero.
- R9: Writing control with bit 4 set starts a transfer only if all of the following hold: the new value has bit 0 set and bit 1 clear, the block is not busy, rfb_mode_i is high, and bits 3:2 of config A AND config B are zero. System status bit 8 shows busy and bit 0 always reads 1.
- R10: A started transfer with a nonzero pixel count sets busy. The access that brings the count to zero clears busy and pulses frame_done_o for one clock. A start with a zero count pulses frame_done_o at once and leaves busy clear.
- R11: Config registers keep only the bits in mask 0x003F1FFF, skip lines keeps 11 bits, and control keeps bits 3:0 (bit 4 reads back 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register word index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while host_ready |
| host_ready | output | 1 | Access completes at this clock edge |
| rfb_mode_i | input | 1 | Display controller is in remote frame buffer mode |
| frame_done_o | output | 1 | One-clock frame-done pulse |
| bus_cs | output | 2 | Per-chip select, active high |
| bus_dc | output | 1 | 1 = data/parameter, 0 = command/status |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |

## Verification
The assertions assume that the host keeps host_sel, host_wr, host_addr and host_wdata steady from its request until the cycle in which host_ready is high. They also assume that rfb_mode_i and bus_din are synchronous to clk. The stimulus meets these assumptions because every host access goes through one task: it drives the port on a falling edge, holds it until ready, then releases it. rfb_mode_i changes only between accesses. The bench's chip model drives bus_din combinationally from the select and data/command lines, so the read value is stable across the whole strobe.

// File: rtl/rfb_pkg.sv
// Shared definitions for the remote frame buffer bus interface.
// Assumes a 4-bit host word index; values outside the map read as zero.
package rfb_pkg;
    typedef enum logic [3:0] {
        RA_SYSSTAT = 4'd0,
        RA_CTRL    = 4'd1,
        RA_PIXCNT  = 4'd2,
        RA_SKIP    = 4'd3,
        RA_CMD     = 4'd4,
        RA_PARAM   = 4'd5,
        RA_DATA    = 4'd6,
        RA_RDDATA  = 4'd7,
        RA_RDSTAT  = 4'd8,
        RA_CFGA    = 4'd9,
        RA_CFGB    = 4'd10
    } rfb_reg_e;

    localparam logic [31:0] CFG_MASK  = 32'h003F_1FFF;
    localparam logic [31:0] CFG_RESET = 32'h0031_0000;
    localparam logic [3:0]  CTRL_RESET = 4'h2;
    localparam int          SKIP_W    = 11;
    localparam int          NCHIP     = 2;
endpackage

// File: rtl/rfb_bus_seq.sv
// Bus beat sequencer: plays out one or two half-word beats for each chip
// in the mask, chip 0 first. Each beat holds the select and a strobe for
// STROBE_CLKS clocks, then has one all-low recovery clock.
// Assumes start is only pulsed while idle and with a nonzero mask.
module rfb_bus_seq #(
    parameter int STROBE_CLKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  chip_mask,
    input  logic        is_read,
    input  logic        two_halves,
    input  logic        dc_in,
    input  logic [31:0] word,
    input  logic [15:0] bus_din,
    output logic [1:0]  bus_cs,
    output logic        bus_dc,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [15:0] bus_dout,
    output logic        done,
    output logic        rx_valid,
    output logic [15:0] rx_data
);
    localparam int TW = $clog2(STROBE_CLKS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(STROBE_CLKS);
    localparam logic [TW-1:0] T_CAP  = TW'(STROBE_CLKS - 1);

    logic          active_q, chip_q, half_q, read_q, two_q, dc_q;
    logic [1:0]    mask_q;
    logic [31:0]   word_q;
    logic [TW-1:0] tick_q;
    logic          strobe_on, last_beat;

    // Decode the current beat position.
    always_comb begin
        strobe_on = active_q && (tick_q < T_LAST);
        last_beat = (!two_q || half_q) && (read_q || chip_q || !mask_q[1]);
        done      = active_q && (tick_q == T_LAST) && last_beat;
        rx_valid  = strobe_on && read_q && (tick_q == T_CAP);
        rx_data   = bus_din;
    end

    // Drive the bus pins from the beat state.
    always_comb begin
        bus_cs   = strobe_on ? (chip_q ? 2'b10 : 2'b01) : 2'b00;
        bus_wr   = strobe_on && !read_q;
        bus_rd   = strobe_on && read_q;
        bus_dc   = strobe_on && dc_q;
        bus_dout = (strobe_on && !read_q) ? (half_q ? word_q[31:16] : word_q[15:0]) : 16'h0;
    end

    // Advance tick, half and chip through the beat list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            chip_q   <= 1'b0;
            half_q   <= 1'b0;
            read_q   <= 1'b0;
            two_q    <= 1'b0;
            dc_q     <= 1'b0;
            mask_q   <= 2'b00;
            word_q   <= 32'h0;
            tick_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            chip_q   <= !chip_mask[0];
            half_q   <= 1'b0;
            read_q   <= is_read;
            two_q    <= two_halves;
            dc_q     <= dc_in;
            mask_q   <= chip_mask;
            word_q   <= word;
            tick_q   <= '0;
        end else if (active_q) begin
            if (tick_q == T_LAST) begin
                tick_q <= '0;
                if (last_beat) begin
                    active_q <= 1'b0;
                end else if (two_q && !half_q) begin
                    half_q <= 1'b1;
                end else begin
                    chip_q <= 1'b1;
                    half_q <= 1'b0;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfb_xfer_ctl.sv
// Frame transfer tracker: pixel counter, busy flag and frame-done pulse.
// Assumes load, step and start never coincide (they come from
// different register accesses).
module rfb_xfer_ctl #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_load,
    input  logic [PIX_W-1:0] cnt_val,
    input  logic             step,
    input  logic             start_req,
    output logic [PIX_W-1:0] pix,
    output logic             busy,
    output logic             frame_done
);
    localparam logic [PIX_W-1:0] ONE = PIX_W'(1);

    // Update counter, busy and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix        <= '0;
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (cnt_load) begin
                pix <= cnt_val;
            end else if (step) begin
                if (pix != '0) pix <= pix - ONE;
                if (busy && (pix <= ONE)) begin
                    busy       <= 1'b0;
                    frame_done <= 1'b1;
                end
            end else if (start_req) begin
                if (pix == '0) frame_done <= 1'b1;
                else           busy       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfb_bus_if.sv
// Remote frame buffer bus interface top: host register file, access
// control and the two sub-blocks. A host access is held until
// host_ready; bus accesses stall until all beats are over.
// Assumes the host keeps its request steady until host_ready.
module rfb_bus_if
    import rfb_pkg::*;
#(
    parameter int STROBE_CLKS = 3,
    parameter int PIX_W       = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_ready,
    input  logic        rfb_mode_i,
    output logic        frame_done_o,
    output logic [1:0]  bus_cs,
    output logic        bus_dc,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [15:0] bus_dout,
    input  logic [15:0] bus_din
);
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} acc_st_e;

    acc_st_e           st_q;
    logic [3:0]        ctrl_q;
    logic [SKIP_W-1:0] skip_q;
    logic [31:0]       cfga_q, cfgb_q;
    logic [15:0]       rxbuf_q;
    logic              step_pend_q;

    logic              acc, bus_op, op_read, op_dc, op_two, op_steps, reg_wr;
    logic [1:0]        first_chip, eff_mask;
    logic              seq_start, seq_done, rx_valid;
    logic [15:0]       rx_data;
    logic [PIX_W-1:0]  pix_w;
    logic              busy_w, start_req;

    // Classify the requested register access.
    always_comb begin
        bus_op = 1'b0; op_read = 1'b0; op_dc = 1'b1; op_two = 1'b0; op_steps = 1'b0;
        if (host_wr) begin
            case (host_addr)
                RA_CMD:    begin bus_op = 1'b1; op_dc = 1'b0; end
                RA_PARAM:  bus_op = 1'b1;
                RA_DATA:   begin bus_op = 1'b1; op_two = 1'b1; op_steps = 1'b1; end
                RA_RDDATA: begin bus_op = 1'b1; op_read = 1'b1; op_steps = 1'b1; end
                RA_RDSTAT: begin bus_op = 1'b1; op_read = 1'b1; op_dc = 1'b0; op_steps = 1'b1; end
                default:   bus_op = 1'b0;
            endcase
        end
        acc        = host_sel && (st_q == ST_IDLE);
        reg_wr     = acc && host_wr && !bus_op;
        first_chip = ctrl_q[2] ? 2'b01 : (ctrl_q[3] ? 2'b10 : 2'b00);
        eff_mask   = op_read ? first_chip : ctrl_q[3:2];
        seq_start  = acc && bus_op && (eff_mask != 2'b00);
        host_ready = (acc && !bus_op) || (st_q == ST_ACK);
        start_req  = reg_wr && (host_addr == RA_CTRL) && host_wdata[4] && host_wdata[0]
                     && !host_wdata[1] && !busy_w && rfb_mode_i
                     && ((cfga_q[3:2] & cfgb_q[3:2]) == 2'b00);
    end

    // Access state: idle, waiting for the sequencer, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            step_pend_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (acc && bus_op) begin
                    st_q        <= (eff_mask == 2'b00) ? ST_ACK : ST_WAIT;
                    step_pend_q <= op_steps;
                end
                ST_WAIT: if (seq_done) st_q <= ST_ACK;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Software-visible registers and the read capture buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            skip_q  <= '0;
            cfga_q  <= CFG_RESET;
            cfgb_q  <= CFG_RESET;
            rxbuf_q <= 16'h0;
        end else begin
            if (rx_valid) rxbuf_q <= rx_data;
            if (reg_wr) begin
                case (host_addr)
                    RA_CTRL: ctrl_q <= host_wdata[3:0];
                    RA_SKIP: skip_q <= host_wdata[SKIP_W-1:0];
                    RA_CFGA: cfga_q <= host_wdata & CFG_MASK;
                    RA_CFGB: cfgb_q <= host_wdata & CFG_MASK;
                    default: ;
                endcase
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (host_addr)
            RA_SYSSTAT: host_rdata = {23'h0, busy_w, 7'h0, 1'b1};
            RA_CTRL:    host_rdata = {28'h0, ctrl_q};
            RA_PIXCNT:  host_rdata = 32'(pix_w);
            RA_SKIP:    host_rdata = 32'(skip_q);
            RA_RDDATA,
            RA_RDSTAT:  host_rdata = {16'h0, rxbuf_q};
            RA_CFGA:    host_rdata = cfga_q;
            RA_CFGB:    host_rdata = cfgb_q;
            default:    host_rdata = 32'h0;
        endcase
    end

    rfb_bus_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .chip_mask(eff_mask),
        .is_read(op_read), .two_halves(op_two), .dc_in(op_dc), .word(host_wdata),
        .bus_din(bus_din), .bus_cs(bus_cs), .bus_dc(bus_dc), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_dout(bus_dout), .done(seq_done),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    rfb_xfer_ctl #(.PIX_W(PIX_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .cnt_load(reg_wr && (host_addr == RA_PIXCNT)),
        .cnt_val(host_wdata[PIX_W-1:0]),
        .step((st_q == ST_ACK) && step_pend_q),
        .start_req(start_req), .pix(pix_w), .busy(busy_w), .frame_done(frame_done_o)
    );
endmodule

// File: rtl/rfb_bus_if_chk.sv
// Protocol checker for rfb_bus_if, attached by bind. Assumes a
// synchronous active-low reset on rst_n.
module rfb_bus_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel,
    input logic       host_wr,
    input logic [3:0] host_addr,
    input logic       host_ready,
    input logic [1:0] bus_cs,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       busy,
    input logic       frame_done
);
    logic ctrl_acc;
    assign ctrl_acc = host_sel && host_wr && (host_addr == 4'd1) && host_ready;

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bus_cs));
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd));
    // R6
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr || bus_rd) |-> (bus_cs != 2'b00));
    // R6
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr || bus_rd) |-> !host_ready);
    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ctrl_acc));
    // R10
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> frame_done);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done);
endmodule

bind rfb_bus_if rfb_bus_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_ready(host_ready), .bus_cs(bus_cs),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .busy(busy_w), .frame_done(frame_done_o)
);

// File: tb/rfb_bus_if_tb.sv
`timescale 1ns/1ps
// Bench for rfb_bus_if: behavioural model (queues, integers) plus a
// per-clock bus monitor.
module rfb_bus_if_tb;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        host_ready, rfb_mode_i = 1'b0, frame_done_o;
    logic [1:0]  bus_cs;
    logic        bus_dc, bus_wr, bus_rd;
    logic [15:0] bus_dout, bus_din;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rfb_bus_if #(.STROBE_CLKS(S), .PIX_W(24)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .rfb_mode_i(rfb_mode_i), .frame_done_o(frame_done_o),
        .bus_cs(bus_cs), .bus_dc(bus_dc), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    // Chip model: fixed answers per chip and per data/status read.
    assign bus_din = bus_cs[0] ? (bus_dc ? 16'h1A2B : 16'h0C01) :
                     bus_cs[1] ? (bus_dc ? 16'h3C4D : 16'h0E02) : 16'h0000;

    // Model state.
    logic [3:0]  m_ctrl = 4'h2;
    int          m_pix = 0;
    bit          m_busy = 0;
    logic [31:0] m_cfga = 32'h0031_0000, m_cfgb = 32'h0031_0000;
    logic [10:0] m_skip = 11'h0;
    logic [15:0] m_rx = 16'h0;
    int          m_done = 0, obs_done = 0;
    logic [19:0] exp_q[$], obs_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: per-clock bus rules, beat capture and done pulse count.
    int   beat_len = 0;
    logic [19:0] cur_beat;
    bit   done_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cs != 2'b00) begin
                if (!(bus_wr ^ bus_rd)) chk(0, "R6 strobe", {30'h0, bus_wr, bus_rd}, 32'h1);
                if (bus_cs == 2'b11)    chk(0, "R2 both selects", 32'(bus_cs), 32'h1);
                if (beat_len == 0) cur_beat = {bus_cs, bus_dc, bus_rd, bus_dout};
                else if (cur_beat != {bus_cs, bus_dc, bus_rd, bus_dout})
                    chk(0, "R6 beat unstable", 32'({bus_cs, bus_dc, bus_rd, bus_dout}), 32'(cur_beat));
                beat_len++;
            end else if (beat_len != 0) begin
                if (beat_len != S) chk(0, "R6 strobe length", beat_len, S);
                obs_q.push_back(cur_beat);
                beat_len = 0;
            end
            if (frame_done_o) begin
                obs_done++;
                if (done_prev) chk(0, "R10 pulse width", 2, 1);
            end
            done_prev = frame_done_o;
        end
    end

    task automatic do_acc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          output logic [31:0] rdv, output int lows);
        host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; lows = 0;
        #1;
        while (!host_ready) begin lows++; @(negedge clk); #1; end
        rdv = host_rdata;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic settle(input string tag);
        @(negedge clk); @(negedge clk); #1;
        chk(obs_done == m_done, {tag, " frame_done count"}, obs_done, m_done);
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return {23'h0, m_busy, 7'h0, 1'b1};
            4'd1: return {28'h0, m_ctrl};
            4'd2: return 32'(m_pix);
            4'd3: return {21'h0, m_skip};
            4'd7, 4'd8: return {16'h0, m_rx};
            4'd9: return m_cfga;
            4'd10: return m_cfgb;
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input logic [3:0] a, input string tag);
        logic [31:0] v; int l;
        do_acc(1'b0, a, 32'h0, v, l);
        chk(v == model_read(a), tag, v, model_read(a));
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input string tag);
        logic [31:0] v; int l; bit go;
        case (a)
            4'd1: begin
                go = d[4] && d[0] && !d[1] && !m_busy && rfb_mode_i
                     && ((m_cfga[3:2] & m_cfgb[3:2]) == 2'b00);
                m_ctrl = d[3:0];
                if (go) begin
                    if (m_pix == 0) m_done++;
                    else m_busy = 1;
                end
            end
            4'd2: m_pix = int'(d[23:0]);
            4'd3: m_skip = d[10:0];
            4'd9: m_cfga = d & 32'h003F_1FFF;
            4'd10: m_cfgb = d & 32'h003F_1FFF;
            default: ;
        endcase
        do_acc(1'b1, a, d, v, l);
        chk(l == 0, {tag, " ready latency"}, l, 0);
        settle(tag);
    endtask

    task automatic bus_op(input logic [3:0] a, input logic [31:0] d, input string tag);
        int n = 0, l; logic [31:0] v; logic [1:0] cs;
        for (int c = 0; c < 2; c++) begin
            cs = (c == 0) ? 2'b01 : 2'b10;
            if (m_ctrl[2 + c]) begin
                case (a)
                    4'd4: begin exp_q.push_back({cs, 1'b0, 1'b0, d[15:0]}); n++; end
                    4'd5: begin exp_q.push_back({cs, 1'b1, 1'b0, d[15:0]}); n++; end
                    4'd6: begin
                        exp_q.push_back({cs, 1'b1, 1'b0, d[15:0]});
                        exp_q.push_back({cs, 1'b1, 1'b0, d[31:16]}); n += 2;
                    end
                    default: if (n == 0) begin
                        exp_q.push_back({cs, (a == 4'd7), 1'b1, 16'h0}); n++;
                        m_rx = (c == 0) ? ((a == 4'd7) ? 16'h1A2B : 16'h0C01)
                                        : ((a == 4'd7) ? 16'h3C4D : 16'h0E02);
                    end
                endcase
            end
        end
        if (a >= 4'd6) begin
            if (m_pix != 0) m_pix--;
            if (m_busy && m_pix == 0) begin m_busy = 0; m_done++; end
        end
        do_acc(1'b1, a, d, v, l);
        chk(l == 1 + n * (S + 1), {tag, " R6 ready latency"}, l, 1 + n * (S + 1));
        settle(tag);
        chk(obs_q.size() == exp_q.size(), {tag, " beat count"}, obs_q.size(), exp_q.size());
        while (exp_q.size() != 0 && obs_q.size() != 0) begin
            logic [19:0] e = exp_q.pop_front();
            logic [19:0] o = obs_q.pop_front();
            chk(o == e, {tag, " beat"}, 32'(o), 32'(e));
        end
        exp_q.delete(); obs_q.delete();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bus_cs == 2'b00 && !bus_wr && !bus_rd, "R1 bus idle", 32'(bus_cs), 0);
        rd_chk(4'd0, "R1 sysstat");
        rd_chk(4'd1, "R1 ctrl");
        rd_chk(4'd9, "R1 cfgA");
        rd_chk(4'd10, "R1 cfgB");
        rd_chk(4'd2, "R1 pixcnt");

        wr_reg(4'd1, 32'h4, "R2 chip0 only");
        bus_op(4'd4, 32'h1234_ABCD, "R3 cmd");
        bus_op(4'd5, 32'hFFFF_0055, "R4 param");
        bus_op(4'd6, 32'hBEEF_1234, "R5 data");
        wr_reg(4'd1, 32'hC, "R2 both");
        bus_op(4'd6, 32'h1111_2222, "R2 R5 data both");
        bus_op(4'd4, 32'h0000_00A5, "R2 R3 cmd both");
        wr_reg(4'd1, 32'h8, "R2 chip1 only");
        bus_op(4'd5, 32'h0000_7777, "R2 R4 param chip1");
        wr_reg(4'd1, 32'h0, "R6 none");
        bus_op(4'd6, 32'h5555_6666, "R6 no chip");

        wr_reg(4'd1, 32'hC, "R7 setup");
        bus_op(4'd7, 32'h0, "R7 data read");
        rd_chk(4'd7, "R7 rxbuf data");
        wr_reg(4'd1, 32'h8, "R7 setup chip1");
        bus_op(4'd8, 32'h0, "R7 status read");
        rd_chk(4'd8, "R7 rxbuf status");

        wr_reg(4'd9, 32'hFFFF_FFFF, "R11 cfgA mask");
        rd_chk(4'd9, "R11 cfgA read");
        wr_reg(4'd3, 32'hFFFF, "R11 skip");
        rd_chk(4'd3, "R11 skip read");
        wr_reg(4'd1, 32'h1F, "R11 ctrl bypass");
        rd_chk(4'd1, "R11 ctrl read");
        rd_chk(4'd0, "R9 bypass no start");

        wr_reg(4'd2, 32'h3, "R8 load");
        wr_reg(4'd9, 32'h4, "R9 cfgA");
        wr_reg(4'd10, 32'h4, "R9 cfgB");
        rfb_mode_i = 1'b1;
        wr_reg(4'd1, 32'h15, "R9 cfg blocks");
        rd_chk(4'd0, "R9 not busy cfg");
        wr_reg(4'd10, 32'h8, "R9 cfgB clear");
        rfb_mode_i = 1'b0;
        wr_reg(4'd1, 32'h15, "R9 mode blocks");
        rd_chk(4'd0, "R9 not busy mode");
        rfb_mode_i = 1'b1;
        wr_reg(4'd1, 32'h14, "R9 enable blocks");
        rd_chk(4'd0, "R9 not busy enable");
        wr_reg(4'd1, 32'h15, "R9 start");
        rd_chk(4'd0, "R9 busy set");
        wr_reg(4'd1, 32'h15, "R9 start while busy");
        bus_op(4'd6, 32'hCAFE_F00D, "R8 step data");
        rd_chk(4'd2, "R8 count 2");
        bus_op(4'd7, 32'h0, "R8 step read");
        rd_chk(4'd0, "R10 still busy");
        bus_op(4'd8, 32'h0, "R10 last step");
        rd_chk(4'd0, "R10 busy clear");
        rd_chk(4'd2, "R8 count zero");
        bus_op(4'd6, 32'h0102_0304, "R8 hold zero");
        rd_chk(4'd2, "R8 still zero");
        wr_reg(4'd1, 32'h15, "R10 zero start");
        rd_chk(4'd0, "R10 zero start not busy");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule